// File: doc/BRIEF.md
# Resistive Heater Temperature Regulator

This block is a digital control loop that holds a sensor die at a temperature the user selects. The die's own resistive heater does two jobs. It is the thermometer, because its resistance rises linearly with temperature. It is also the actuator. At each control cycle the block asks an external 10-bit converter for a heater voltage sample and then for a heater current sample, and handshakes each request. It divides one sample by the other to get the present heater resistance. It turns that resistance into a temperature using the calibrated reference resistance and a coefficient of 0.006 per degree, measured from a 20.0 °C reference point. Finally it writes a proportional drive code to a DAC that sets the gate voltage of the heater power transistor.

A calibration mode lets the user load the heater's manufactured resistance and the temperature setpoint. Both values are clamped to their legal ranges. While calibration is active the heater is held off. The loaded values reach the loop when the first control cycle after calibration starts. Control cycles are paced by an internal tick whose period is programmable. All resistances use units of 0.01 Ω and all temperatures use units of 0.1 °C.

Top module: `heater_temp_regulator`

## Requirements
- R1: After reset, `dac_code` is 0, `range_limited` and `sensor_fault` are low, `adc_start` is low, the reference resistance is 2500 (25.00 Ω) and the setpoint is 250 (25.0 °C).
- R2: A setpoint entry is clamped to the range 200..500 (20.0 °C to 50.0 °C).
- R3: A resistance entry is clamped to the range 100..3000 (1.00 Ω to 30.00 Ω). An entry above 3000 sets `range_limited`. An entry of 3000 or less clears it.
- R4: Writes made while `cal_mode` is low have no effect on the stored resistance, the stored setpoint or `range_limited`.
- R5: For a voltage code V and a nonzero current code I, the resistance is R = floor(V·100/I), saturated to 65535. The temperature is 200 + floor((R−Rref)·5000/(3·Rref)) when R ≥ Rref, and 200 − floor((Rref−R)·5000/(3·Rref)) otherwise. The result is saturated to signed 16 bits and appears on `temp_meas` in two's complement.
- R6: At the end of a cycle, with err = setpoint − temperature: if err ≤ 0 then `dac_code` is 0; otherwise `dac_code` = min(err·`kp_gain` + `hold_code`, 1023).
- R7: While `cal_mode` is high, `dac_code` is 0 from the next clock onward, no conversion is requested, and any cycle in progress is abandoned.
- R8: Resistance and setpoint values loaded in calibration are used by the first control cycle that starts after `cal_mode` falls.
- R9: A current sample of 0 leaves `dac_code` and `temp_meas` unchanged and sets `sensor_fault`. The next cycle with a nonzero current clears it.
- R10: Ticks occur every `tick_period`+1 clocks. A cycle starts only on a tick while the loop is idle. Each `adc_start` is a one-clock pulse: first with `adc_sel`=0 (voltage), then, after `adc_done`, with `adc_sel`=1 (current).
- R11: Reset is asynchronous. Asserting `rst_n` low clears `dac_code` and the flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_period | input | 16 | Clocks between control cycles, minus one |
| cal_mode | input | 1 | Calibration mode; heater forced off while high |
| cal_res_we | input | 1 | Load strobe for the reference resistance |
| cal_res_val | input | 16 | Reference resistance entry, 0.01 Ω units |
| cal_sp_we | input | 1 | Load strobe for the setpoint |
| cal_sp_val | input | 16 | Setpoint entry, 0.1 °C units |
| kp_gain | input | 8 | Proportional gain, in DAC codes per 0.1 °C |
| hold_code | input | 10 | Constant added to the drive whenever the die is below setpoint |
| adc_start | output | 1 | One-clock conversion request |
| adc_sel | output | 1 | Channel select: 0 for voltage, 1 for current |
| adc_done | input | 1 | Conversion complete; `adc_data` is valid |
| adc_data | input | 10 | Conversion result |
| dac_code | output | 10 | Heater drive code |
| temp_meas | output | 16 | Last measured temperature, signed, 0.1 °C units |
| range_limited | output | 1 | Last resistance entry was above the cap |
| sensor_fault | output | 1 | Last current sample was zero |

## Verification
The bench sweeps the voltage code finely around the calibrated resistance, so the sign of R−Rref and the direction of truncation are both exercised. A design that rounded the wrong way, or truncated before taking the magnitude, would be off by one degree-tenth on the cold side. Setpoints above the measured temperature are crossed with a range of gains to reach the 1023 ceiling, which a missing saturation would wrap. Separate cycles cover the hot case, the exact cap of 3000, the floor of 100, and entries made outside calibration, which a leaky write path would apply. A zero current sample must keep the previous drive code; a design that divided anyway would produce a wrong drive instead of holding. A reset asserted between clock edges must clear the output immediately.

// File: rtl/htr_pkg.sv
package htr_pkg;
  localparam int ADC_W  = 10;
  localparam int DAC_W  = 10;
  localparam int RES_W  = 16;
  localparam int TMP_W  = 16;
  localparam int GAIN_W = 8;
  localparam int DIV_W  = 32;
  localparam int PER_W  = 16;
  localparam int PROD_W = TMP_W + GAIN_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_V, ST_WAIT_V, ST_REQ_I, ST_WAIT_I, ST_DIV_R, ST_DIV_T, ST_UPDATE
  } htr_state_e;

  // keep a value inside [lo, hi]
  function automatic logic [RES_W-1:0] clamp_range(input logic [RES_W-1:0] x,
                                                   input logic [RES_W-1:0] lo,
                                                   input logic [RES_W-1:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // divider quotient saturated to the resistance width
  function automatic logic [RES_W-1:0] sat_quot(input logic [DIV_W-1:0] q);
    if (q > DIV_W'({RES_W{1'b1}})) return '1;
    return q[RES_W-1:0];
  endfunction

  // reference temperature plus or minus the scaled deviation, saturated to signed TMP_W
  function automatic logic signed [TMP_W-1:0] temp_from_mag(input logic neg,
                                                            input logic [DIV_W-1:0] mag,
                                                            input logic signed [TMP_W-1:0] tref);
    logic signed [DIV_W+1:0] m;
    logic signed [DIV_W+1:0] s;
    m = $signed({2'b00, mag});
    s = neg ? (DIV_W+2)'(tref) - m : (DIV_W+2)'(tref) + m;
    if (s > (DIV_W+2)'(32767)) return 16'sh7FFF;
    if (s < (DIV_W+2)'(-32768)) return 16'sh8000;
    return $signed(s[TMP_W-1:0]);
  endfunction

  // proportional drive with hold offset, zero at or above setpoint, saturated
  function automatic logic [DAC_W-1:0] dac_law(input logic signed [TMP_W-1:0] temp,
                                               input logic [RES_W-1:0] sp,
                                               input logic [GAIN_W-1:0] gain,
                                               input logic [DAC_W-1:0] hold);
    logic signed [TMP_W+1:0] err;
    logic [PROD_W-1:0] prod;
    err = $signed({2'b00, sp}) - (TMP_W+2)'(temp);
    if (err <= 0) return '0;
    prod = PROD_W'(err[TMP_W:0]) * PROD_W'(gain) + PROD_W'(hold);
    if (prod > PROD_W'({DAC_W{1'b1}})) return '1;
    return prod[DAC_W-1:0];
  endfunction
endpackage

// File: rtl/htr_divider.sv
module htr_divider #(
  parameter int W = htr_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  q;
  logic [W-1:0]  d;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [W:0]    shifted;
  logic          fits;

  assign shifted = {rem[W-1:0], q[W-1]};
  assign fits    = shifted >= {1'b0, d};
  assign quot    = q;

  // restoring division: one quotient bit per clock, W clocks per result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      q    <= '0;
      d    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        q    <= num;
        d    <= den;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= fits ? shifted - {1'b0, d} : shifted;
        q   <= {q[W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/htr_tick.sv
module htr_tick #(
  parameter int PW = htr_pkg::PER_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= period) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/htr_calib.sv
module htr_calib
  import htr_pkg::*;
#(
  parameter int R_DEF  = 2500,
  parameter int R_MIN  = 100,
  parameter int R_MAX  = 3000,
  parameter int SP_DEF = 250,
  parameter int SP_MIN = 200,
  parameter int SP_MAX = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_mode,
  input  logic             res_we,
  input  logic [RES_W-1:0] res_val,
  input  logic             sp_we,
  input  logic [RES_W-1:0] sp_val,
  output logic [RES_W-1:0] rref_sh,
  output logic [RES_W-1:0] sp_sh,
  output logic             range_limited
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rref_sh       <= RES_W'(R_DEF);
      sp_sh         <= RES_W'(SP_DEF);
      range_limited <= 1'b0;
    end else if (cal_mode) begin
      if (res_we) begin
        rref_sh       <= clamp_range(res_val, RES_W'(R_MIN), RES_W'(R_MAX));
        range_limited <= res_val > RES_W'(R_MAX);
      end
      if (sp_we) begin
        sp_sh <= clamp_range(sp_val, RES_W'(SP_MIN), RES_W'(SP_MAX));
      end
    end
  end
endmodule

// File: rtl/htr_ctrl.sv
module htr_ctrl
  import htr_pkg::*;
#(
  parameter int R_DEF   = 2500,
  parameter int SP_DEF  = 250,
  parameter int T_REF   = 200,
  parameter int R_SCALE = 100,
  parameter int TC_NUM  = 5000,
  parameter int TC_DEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cal_mode,
  input  logic [RES_W-1:0]  rref_sh,
  input  logic [RES_W-1:0]  sp_sh,
  input  logic [GAIN_W-1:0] kp_gain,
  input  logic [DAC_W-1:0]  hold_code,
  output logic              adc_start,
  output logic              adc_sel,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_data,
  output logic              div_start,
  output logic [DIV_W-1:0]  div_num,
  output logic [DIV_W-1:0]  div_den,
  input  logic              div_done,
  input  logic [DIV_W-1:0]  div_quot,
  output logic [DAC_W-1:0]  dac_code,
  output logic [TMP_W-1:0]  temp_meas,
  output logic              sensor_fault,
  output logic [RES_W-1:0]  sp_act,
  output logic              cyc_start,
  output logic              upd_evt
);
  htr_state_e              state;
  logic [ADC_W-1:0]        v_q;
  logic [RES_W-1:0]        rref_act;
  logic                    t_neg;
  logic signed [TMP_W-1:0] temp_q;
  logic [RES_W-1:0]        r_now;
  logic                    r_below;
  logic [RES_W-1:0]        r_gap;
  logic                    i_zero_evt;
  logic                    i_good_evt;
  logic                    r_done_evt;

  assign temp_meas  = temp_q;
  assign adc_start  = (state == ST_REQ_V || state == ST_REQ_I) && !cal_mode;
  assign adc_sel    = (state == ST_REQ_I || state == ST_WAIT_I);
  assign cyc_start  = (state == ST_IDLE) && tick && !cal_mode;
  assign upd_evt    = (state == ST_UPDATE) && !cal_mode;
  assign i_zero_evt = (state == ST_WAIT_I) && adc_done && (adc_data == '0) && !cal_mode;
  assign i_good_evt = (state == ST_WAIT_I) && adc_done && (adc_data != '0) && !cal_mode;
  assign r_done_evt = (state == ST_DIV_R) && div_done && !cal_mode;

  // resistance just produced by the divider and its distance from the reference
  assign r_now   = sat_quot(div_quot);
  assign r_below = r_now < rref_act;
  assign r_gap   = r_below ? rref_act - r_now : r_now - rref_act;

  always_comb begin
    div_start = 1'b0;
    div_num   = '0;
    div_den   = '0;
    if (i_good_evt) begin
      div_start = 1'b1;
      div_num   = DIV_W'(v_q) * DIV_W'(R_SCALE);
      div_den   = DIV_W'(adc_data);
    end else if (r_done_evt) begin
      div_start = 1'b1;
      div_num   = DIV_W'(r_gap) * DIV_W'(TC_NUM);
      div_den   = DIV_W'(rref_act) * DIV_W'(TC_DEN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      v_q          <= '0;
      rref_act     <= RES_W'(R_DEF);
      sp_act       <= RES_W'(SP_DEF);
      t_neg        <= 1'b0;
      temp_q       <= TMP_W'(T_REF);
      dac_code     <= '0;
      sensor_fault <= 1'b0;
    end else if (cal_mode) begin
      state    <= ST_IDLE;
      dac_code <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (tick) begin
          rref_act <= rref_sh;
          sp_act   <= sp_sh;
          state    <= ST_REQ_V;
        end
        ST_REQ_V:  state <= ST_WAIT_V;
        ST_WAIT_V: if (adc_done) begin
          v_q   <= adc_data;
          state <= ST_REQ_I;
        end
        ST_REQ_I:  state <= ST_WAIT_I;
        ST_WAIT_I: if (i_zero_evt) begin
          sensor_fault <= 1'b1;
          state        <= ST_IDLE;
        end else if (i_good_evt) begin
          state <= ST_DIV_R;
        end
        ST_DIV_R: if (r_done_evt) begin
          t_neg <= r_below;
          state <= ST_DIV_T;
        end
        ST_DIV_T: if (div_done) begin
          temp_q <= temp_from_mag(t_neg, div_quot, TMP_W'(T_REF));
          state  <= ST_UPDATE;
        end
        ST_UPDATE: begin
          dac_code     <= dac_law(temp_q, sp_act, kp_gain, hold_code);
          sensor_fault <= 1'b0;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/heater_temp_regulator.sv
module heater_temp_regulator
  import htr_pkg::*;
#(
  parameter int R_DEF   = 2500,
  parameter int R_MIN   = 100,
  parameter int R_MAX   = 3000,
  parameter int SP_DEF  = 250,
  parameter int SP_MIN  = 200,
  parameter int SP_MAX  = 500,
  parameter int T_REF   = 200,
  parameter int R_SCALE = 100,
  parameter int TC_NUM  = 5000,
  parameter int TC_DEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PER_W-1:0]  tick_period,
  input  logic              cal_mode,
  input  logic              cal_res_we,
  input  logic [RES_W-1:0]  cal_res_val,
  input  logic              cal_sp_we,
  input  logic [RES_W-1:0]  cal_sp_val,
  input  logic [GAIN_W-1:0] kp_gain,
  input  logic [DAC_W-1:0]  hold_code,
  output logic              adc_start,
  output logic              adc_sel,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_data,
  output logic [DAC_W-1:0]  dac_code,
  output logic [TMP_W-1:0]  temp_meas,
  output logic              range_limited,
  output logic              sensor_fault
);
  logic             tick;
  logic [RES_W-1:0] rref_sh;
  logic [RES_W-1:0] sp_sh;
  logic [RES_W-1:0] sp_act;
  logic             cyc_start;
  logic             upd_evt;
  logic             div_start;
  logic             div_done;
  logic [DIV_W-1:0] div_num;
  logic [DIV_W-1:0] div_den;
  logic [DIV_W-1:0] div_quot;

  htr_tick #(.PW(PER_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(tick)
  );

  htr_calib #(
    .R_DEF(R_DEF), .R_MIN(R_MIN), .R_MAX(R_MAX),
    .SP_DEF(SP_DEF), .SP_MIN(SP_MIN), .SP_MAX(SP_MAX)
  ) calib_i (
    .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode),
    .res_we(cal_res_we), .res_val(cal_res_val),
    .sp_we(cal_sp_we), .sp_val(cal_sp_val),
    .rref_sh(rref_sh), .sp_sh(sp_sh), .range_limited(range_limited)
  );

  htr_ctrl #(
    .R_DEF(R_DEF), .SP_DEF(SP_DEF), .T_REF(T_REF),
    .R_SCALE(R_SCALE), .TC_NUM(TC_NUM), .TC_DEN(TC_DEN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cal_mode(cal_mode),
    .rref_sh(rref_sh), .sp_sh(sp_sh), .kp_gain(kp_gain), .hold_code(hold_code),
    .adc_start(adc_start), .adc_sel(adc_sel), .adc_done(adc_done), .adc_data(adc_data),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_done(div_done), .div_quot(div_quot),
    .dac_code(dac_code), .temp_meas(temp_meas), .sensor_fault(sensor_fault),
    .sp_act(sp_act), .cyc_start(cyc_start), .upd_evt(upd_evt)
  );

  htr_divider #(.W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .quot(div_quot)
  );
endmodule

// File: rtl/htr_checker.sv
module htr_checker
  import htr_pkg::*;
#(
  parameter int R_MIN  = 100,
  parameter int R_MAX  = 3000,
  parameter int SP_MIN = 200,
  parameter int SP_MAX = 500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cal_mode,
  input logic             adc_start,
  input logic             adc_sel,
  input logic [DAC_W-1:0] dac_code,
  input logic [TMP_W-1:0] temp_meas,
  input logic             sensor_fault,
  input logic             range_limited,
  input logic [RES_W-1:0] rref_sh,
  input logic [RES_W-1:0] sp_sh,
  input logic [RES_W-1:0] sp_act,
  input logic             cyc_start,
  input logic             upd_evt
);
  assert_sp_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sp_sh >= RES_W'(SP_MIN) && sp_sh <= RES_W'(SP_MAX));

  assert_res_capped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rref_sh >= RES_W'(R_MIN) && rref_sh <= RES_W'(R_MAX));

  assert_no_write_outside_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode |=> $stable(rref_sh) && $stable(sp_sh) && $stable(range_limited));

  assert_hot_means_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt && ($signed({temp_meas[TMP_W-1], temp_meas}) >= $signed({1'b0, sp_act}))
    |=> dac_code == '0);

  assert_heater_off_in_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |=> dac_code == '0);

  assert_no_request_in_cal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_mode |=> !adc_start);

  assert_fault_keeps_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sensor_fault) |-> $stable(dac_code));

  assert_request_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_voltage_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> cal_mode || (adc_start && !adc_sel));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clears_R11: assert (dac_code == '0 && !sensor_fault && !range_limited);
    end
  end
endmodule

bind heater_temp_regulator htr_checker #(
  .R_MIN(R_MIN), .R_MAX(R_MAX), .SP_MIN(SP_MIN), .SP_MAX(SP_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .adc_start(adc_start),
  .adc_sel(adc_sel), .dac_code(dac_code), .temp_meas(temp_meas),
  .sensor_fault(sensor_fault), .range_limited(range_limited),
  .rref_sh(rref_sh), .sp_sh(sp_sh), .sp_act(sp_act),
  .cyc_start(cyc_start), .upd_evt(upd_evt)
);

// File: tb/heater_temp_regulator_tb.sv
module heater_temp_regulator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tick_period = 16'd255;
  logic        cal_mode = 1'b0;
  logic        cal_res_we = 1'b0;
  logic [15:0] cal_res_val = '0;
  logic        cal_sp_we = 1'b0;
  logic [15:0] cal_sp_val = '0;
  logic [7:0]  kp_gain = 8'd4;
  logic [9:0]  hold_code = 10'd100;
  logic        adc_start;
  logic        adc_sel;
  logic        adc_done = 1'b0;
  logic [9:0]  adc_data = '0;
  logic [9:0]  dac_code;
  logic [15:0] temp_meas;
  logic        range_limited;
  logic        sensor_fault;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  longint b_rref = 2500;
  longint b_sp = 250;
  longint last_dac = 0;
  longint last_temp = 200;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  heater_temp_regulator dut_i (
    .clk(clk), .rst_n(rst_n), .tick_period(tick_period), .cal_mode(cal_mode),
    .cal_res_we(cal_res_we), .cal_res_val(cal_res_val),
    .cal_sp_we(cal_sp_we), .cal_sp_val(cal_sp_val),
    .kp_gain(kp_gain), .hold_code(hold_code),
    .adc_start(adc_start), .adc_sel(adc_sel), .adc_done(adc_done), .adc_data(adc_data),
    .dac_code(dac_code), .temp_meas(temp_meas),
    .range_limited(range_limited), .sensor_fault(sensor_fault)
  );

  // reference arithmetic, written directly from the requirements
  function automatic longint m_temp(longint v, longint i, longint rref);
    longint r, d, mag, t;
    r = (v * 100) / i;
    if (r > 65535) r = 65535;
    d = r - rref;
    mag = ((d < 0) ? -d : d) * 5000 / (3 * rref);
    t = (d < 0) ? 200 - mag : 200 + mag;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic longint m_dac(longint t, longint sp, longint kp, longint hold);
    longint err, x;
    err = sp - t;
    if (err <= 0) return 0;
    x = err * kp + hold;
    return (x > 1023) ? 1023 : x;
  endfunction

  function automatic longint m_clamp(longint x, longint lo, longint hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_req(output longint t_at, input bit want_sel);
    while (adc_start !== 1'b1) @(negedge clk);
    t_at = cyc;
    chk(adc_sel == want_sel, "R10 channel order", adc_sel, want_sel);
    @(negedge clk);
    chk(adc_start == 1'b0, "R10 request is one clock", adc_start, 0);
  endtask

  task automatic serve(input int val);
    adc_data = val[9:0];
    adc_done = 1'b1;
    @(negedge clk);
    adc_done = 1'b0;
  endtask

  task automatic run_cycle(input int v, input int i, output longint tv);
    longint ti;
    wait_req(tv, 1'b0);
    serve(v);
    wait_req(ti, 1'b1);
    serve(i);
    repeat (100) @(negedge clk);
  endtask

  task automatic do_cycle(input int v, input int i, input string tag);
    longint tv, et, ed;
    run_cycle(v, i, tv);
    if (i == 0) begin
      chk(dac_code == last_dac, "R9 drive kept on zero current", dac_code, last_dac);
      chk(longint'($signed(temp_meas)) == last_temp, "R9 temperature kept", $signed(temp_meas), last_temp);
      chk(sensor_fault == 1'b1, "R9 fault raised", sensor_fault, 1);
    end else begin
      et = m_temp(v, i, b_rref);
      ed = m_dac(et, b_sp, kp_gain, hold_code);
      chk(longint'($signed(temp_meas)) == et, {tag, " temperature"}, $signed(temp_meas), et);
      chk(dac_code == ed, {tag, " drive"}, dac_code, ed);
      chk(sensor_fault == 1'b0, "R9 fault clear after good cycle", sensor_fault, 0);
      last_dac = ed;
      last_temp = et;
    end
  endtask

  task automatic cal_res(input int val);
    @(negedge clk);
    cal_res_val = val[15:0];
    cal_res_we = 1'b1;
    @(negedge clk);
    cal_res_we = 1'b0;
    if (cal_mode) b_rref = m_clamp(val, 100, 3000);
  endtask

  task automatic cal_sp(input int val);
    @(negedge clk);
    cal_sp_val = val[15:0];
    cal_sp_we = 1'b1;
    @(negedge clk);
    cal_sp_we = 1'b0;
    if (cal_mode) b_sp = m_clamp(val, 200, 500);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint t1, t2;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dac_code == 0, "R1 drive after reset", dac_code, 0);
    chk(range_limited == 0, "R1 range flag after reset", range_limited, 0);
    chk(sensor_fault == 0, "R1 fault after reset", sensor_fault, 0);
    chk(adc_start == 0, "R1 no request in reset", adc_start, 0);
    rst_n = 1'b1;

    // R1 defaults used by the first cycle (Rref 2500, setpoint 250)
    do_cycle(1000, 40, "R1 R5 R6 default cycle");

    // R5 R6 sweep around the reference resistance, both signs
    for (int v = 960; v <= 1023; v += 3) do_cycle(v, 40, "R5 R6 sweep");

    // R10 tick pacing
    run_cycle(1000, 40, t1);
    run_cycle(1000, 40, t2);
    chk((t2 - t1) == 256, "R10 tick spacing", t2 - t1, 256);

    // R4 writes outside calibration are ignored
    cal_res(150);
    cal_sp(480);
    // R7 calibration freezes the loop
    @(negedge clk);
    cal_mode = 1'b1;
    @(negedge clk);
    chk(dac_code == 0, "R7 heater off in calibration", dac_code, 0);
    seen = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (adc_start) seen = 1'b1;
    end
    chk(seen == 1'b0, "R7 no requests in calibration", seen, 0);
    // R2 R3 clamps at the top
    cal_sp(600);
    cal_res(3500);
    chk(range_limited == 1, "R3 range flag on oversize entry", range_limited, 1);
    @(negedge clk);
    cal_mode = 1'b0;
    // R8 new values used by the first cycle after release; R4 ignored writes absent
    do_cycle(1023, 30, "R2 R3 R4 R8 cycle after calibration");

    // R11 asynchronous reset between edges
    @(negedge clk);
    #5 rst_n = 1'b0;
    #1;
    chk(dac_code == 0, "R11 drive cleared without clock", dac_code, 0);
    chk(range_limited == 0, "R11 range flag cleared", range_limited, 0);
    @(negedge clk);
    rst_n = 1'b1;
    b_rref = 2500;
    b_sp = 250;
    last_dac = 0;
    last_temp = 200;
    do_cycle(1000, 40, "R1 R11 defaults restored");

    // R2 low clamp, R3 flag clear, R6 hot die gives zero drive
    @(negedge clk);
    cal_mode = 1'b1;
    cal_sp(50);
    cal_res(3000);
    chk(range_limited == 0, "R3 flag clear at exact cap", range_limited, 0);
    cal_res(2000);
    @(negedge clk);
    cal_mode = 1'b0;
    do_cycle(1023, 40, "R2 R6 hot die");
    chk(dac_code == 0, "R6 zero drive at or above setpoint", dac_code, 0);

    // R3 floor of resistance entries, R6 saturation
    @(negedge clk);
    cal_mode = 1'b1;
    cal_res(0);
    @(negedge clk);
    cal_mode = 1'b0;
    do_cycle(10, 100, "R3 R5 floor resistance");
    chk(dac_code == 1023, "R6 saturated drive", dac_code, 1023);

    // R6 large gain saturation, then R9 zero current and recovery
    @(negedge clk);
    cal_mode = 1'b1;
    cal_sp(500);
    cal_res(3000);
    @(negedge clk);
    cal_mode = 1'b0;
    kp_gain = 8'd255;
    hold_code = 10'd1000;
    do_cycle(900, 40, "R5 R6 cold saturation");
    kp_gain = 8'd1;
    hold_code = 10'd3;
    do_cycle(1023, 32, "R5 R6 near setpoint");
    do_cycle(700, 0, "R9 zero current");
    do_cycle(1023, 32, "R9 recovery");

    // R6 gain sweep near the setpoint
    @(negedge clk);
    cal_mode = 1'b1;
    cal_res(2500);
    @(negedge clk);
    cal_mode = 1'b0;
    for (int k = 0; k < 16; k++) begin
      kp_gain = k[7:0];
      hold_code = 10'(k * 50);
      do_cycle(880, 30, "R6 gain sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule